// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block lets on-chip logic read and program a serial EEPROM holding 64 words of 16 bits over a three-wire link made of a select line, a serial clock and a data line in each direction. A client presents one command at a time: a strobe, an operation code, a word address and, for programming, a data word. The controller builds the serial frame, paces the serial clock from the system clock and returns a one-cycle completion pulse. On that pulse it also presents the captured word for a read, and a flag that reports a programming operation that never finished.

Programming operations are timed by the memory itself. After such a frame the controller drops select for a guaranteed gap and then raises it again. It then watches the returned data line until the memory reports ready, or until its own poll budget runs out. Every command ends with select held low for the gap, so back-to-back commands always respect the minimum deselect time. The memory powers up with writes disabled, so the client issues the enable command before any programming command.

Top module: `uwire_eeprom_host`

## Requirements
- R1: A frame is sent MSB first as a 1 start bit, a 2-bit opcode and 6 address bits. The `cmd_op` codes are 0 read, 1 write, 2 erase, 3 erase-all, 4 write-all, 5 write-enable and 6 write-disable (7 is sent as write-disable). Read sends opcode 10, write 01 and erase 11, each with `cmd_addr`. The other four send opcode 00 with address bits [5:4] set to 11 for enable, 00 for disable, 10 for erase-all and 01 for write-all, and address bits [3:0] zero. Write and write-all then send the 16 data bits, MSB first.
- R2: Each serial clock high phase and each low phase between two rising edges inside a frame lasts exactly `DIV` system cycles. Select is high for at least `DIV` cycles before the first rising edge. A frame has 9 rising edges, 25 when it carries data, and 26 for a read.
- R3: The data output to the memory never changes while the serial clock is high.
- R4: For a read, the bit returned after the last address bit is discarded. The next 16 returned bits, MSB first, appear on `rdata` when `done` pulses, and `rdata` holds that value until the next read completes.
- R5: After a write, erase, erase-all or write-all frame, select goes low for `CS_GAP` cycles and then high again with no serial clock. The controller waits `DIV` cycles and then ends the poll at the first cycle the returned line reads 1.
- R6: If the returned line is not 1 within `POLL_MAX` cycles of select rising for the poll, the poll ends and `timeout_err` is 1 when `done` pulses. The flag is cleared when the next command is accepted.
- R7: Select stays low for at least `CS_GAP` cycles before `done` pulses, and it never rises after fewer than `CS_GAP` low cycles.
- R8: `done` is a single-cycle pulse, and the serial clock is low whenever select is low.
- R9: `cmd_valid` is acted on only when the controller is idle. A strobe during a command starts no extra frame and no extra `done`.
- R10: Read, write-enable and write-disable frames have no poll: select rises exactly once per command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_op | input | 3 | Operation code (see R1) |
| cmd_addr | input | 6 | Word address |
| cmd_wdata | input | 16 | Data word for write and write-all |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Last word read |
| timeout_err | output | 1 | Poll budget expired on the last command |
| ee_cs | output | 1 | Select to the memory, active high |
| ee_sclk | output | 1 | Serial clock to the memory |
| ee_di | output | 1 | Serial data to the memory |
| ee_do | input | 1 | Serial data and ready/busy from the memory |

## Verification
The bench builds the controller with `DIV`=2, `CS_GAP`=5 and `POLL_MAX`=200. This makes each frame about a hundred cycles long, so all 64 addresses can be written and read back several times within the run. A behavioural memory model holds busy for 30 cycles after each programming frame, which exercises the real poll path. A stuck-busy mode pushes the poll to the `POLL_MAX` limit within a few hundred cycles. Phase lengths, gap lengths and rising-edge counts are measured against these small values in every frame.

// File: rtl/ueh_pkg.sv
package ueh_pkg;

  localparam int unsigned ADDR_BITS  = 6;
  localparam int unsigned WORD_BITS  = 16;
  localparam int unsigned HDR_BITS   = 1 + 2 + ADDR_BITS;
  localparam int unsigned FRAME_BITS = HDR_BITS + WORD_BITS;
  localparam int unsigned RD_FIRST   = HDR_BITS + 1;
  localparam int unsigned RD_SLOTS   = RD_FIRST + WORD_BITS;
  localparam int unsigned SLOT_W     = $clog2(RD_SLOTS + 1);

  typedef enum logic [2:0] {
    OP_READ       = 3'd0,
    OP_WRITE      = 3'd1,
    OP_ERASE      = 3'd2,
    OP_ERASE_ALL  = 3'd3,
    OP_WRITE_ALL  = 3'd4,
    OP_WR_ENABLE  = 3'd5,
    OP_WR_DISABLE = 3'd6
  } ueh_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_SHIFT, S_GAP_MID, S_POLL, S_GAP_END
  } ueh_state_e;

  // start bit, 2-bit opcode, address field
  function automatic logic [HDR_BITS-1:0] frame_head(ueh_op_e op, logic [ADDR_BITS-1:0] a);
    logic [ADDR_BITS-1:0] sub;
    sub = '0;
    case (op)
      OP_READ:      return {1'b1, 2'b10, a};
      OP_WRITE:     return {1'b1, 2'b01, a};
      OP_ERASE:     return {1'b1, 2'b11, a};
      OP_ERASE_ALL: sub[ADDR_BITS-1 -: 2] = 2'b10;
      OP_WRITE_ALL: sub[ADDR_BITS-1 -: 2] = 2'b01;
      OP_WR_ENABLE: sub[ADDR_BITS-1 -: 2] = 2'b11;
      default:      sub[ADDR_BITS-1 -: 2] = 2'b00;
    endcase
    return {1'b1, 2'b00, sub};
  endfunction

  function automatic logic carries_data(ueh_op_e op);
    return (op == OP_WRITE) || (op == OP_WRITE_ALL);
  endfunction

  function automatic logic needs_poll(ueh_op_e op);
    return (op == OP_WRITE) || (op == OP_ERASE) ||
           (op == OP_ERASE_ALL) || (op == OP_WRITE_ALL);
  endfunction

  function automatic logic [SLOT_W-1:0] slot_total(ueh_op_e op);
    if (op == OP_READ)     return SLOT_W'(RD_SLOTS);
    if (carries_data(op))  return SLOT_W'(FRAME_BITS);
    return SLOT_W'(HDR_BITS);
  endfunction

endpackage

// File: rtl/ueh_tick.sv
module ueh_tick #(
  parameter int unsigned DIV = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ueh_shift.sv
module ueh_shift #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         sin,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (load)   q <= load_val;
    else if (shift)  q <= {q[W-2:0], sin};
  end
endmodule

// File: rtl/uwire_eeprom_host.sv
module uwire_eeprom_host
  import ueh_pkg::*;
#(
  parameter int unsigned DIV      = 32,
  parameter int unsigned CS_GAP   = 32,
  parameter int unsigned POLL_MAX = 2000000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [2:0]  cmd_op,
  input  logic [5:0]  cmd_addr,
  input  logic [15:0] cmd_wdata,
  output logic        done,
  output logic [15:0] rdata,
  output logic        timeout_err,
  output logic        ee_cs,
  output logic        ee_sclk,
  output logic        ee_di,
  input  logic        ee_do
);
  localparam int unsigned WMAX = (POLL_MAX > CS_GAP) ? POLL_MAX : CS_GAP;
  localparam int unsigned WCW  = $clog2(WMAX + 1);

  ueh_state_e          st;
  ueh_op_e             op_r;
  ueh_op_e             op_in;
  logic [SLOT_W-1:0]   slot, nslots;
  logic [WCW-1:0]      wcnt;
  logic                cs_r, sclk_r, err_r, done_r;
  logic [WORD_BITS-1:0] rdata_r;
  logic [FRAME_BITS-1:0] tx_q, tx_load;
  logic [WORD_BITS-1:0] rx_q;

  // named internal events
  logic accept, run, tick, rise_now, fall_now, last_slot, cap_now;
  logic gap_over, poll_ready, poll_expire;

  assign op_in      = ueh_op_e'(cmd_op);
  assign accept     = (st == S_IDLE) && cmd_valid;
  assign run        = (st == S_SETUP) || (st == S_SHIFT);
  assign rise_now   = (st == S_SHIFT) && tick && !sclk_r;
  assign fall_now   = (st == S_SHIFT) && tick && sclk_r;
  assign last_slot  = (slot == nslots - 1'b1);
  assign cap_now    = rise_now && (op_r == OP_READ) && (slot >= SLOT_W'(RD_FIRST));
  assign gap_over   = (wcnt == WCW'(CS_GAP - 1));
  assign poll_ready = (st == S_POLL) && ee_do && (wcnt >= WCW'(DIV));
  assign poll_expire = (st == S_POLL) && !poll_ready && (wcnt == WCW'(POLL_MAX - 1));

  assign tx_load = {frame_head(op_in, cmd_addr),
                    carries_data(op_in) ? cmd_wdata : {WORD_BITS{1'b0}}};

  ueh_tick #(.DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  ueh_shift #(.W(FRAME_BITS)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(tx_load),
    .shift(fall_now && !last_slot), .sin(1'b0), .q(tx_q)
  );

  ueh_shift #(.W(WORD_BITS)) u_rx (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val({WORD_BITS{1'b0}}),
    .shift(cap_now), .sin(ee_do), .q(rx_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      op_r    <= OP_WR_DISABLE;
      slot    <= '0;
      nslots  <= '0;
      wcnt    <= '0;
      cs_r    <= 1'b0;
      sclk_r  <= 1'b0;
      err_r   <= 1'b0;
      done_r  <= 1'b0;
      rdata_r <= '0;
    end else begin
      done_r <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          op_r   <= op_in;
          nslots <= slot_total(op_in);
          slot   <= '0;
          cs_r   <= 1'b1;
          sclk_r <= 1'b0;
          err_r  <= 1'b0;
          st     <= S_SETUP;
        end
        S_SETUP: if (tick) st <= S_SHIFT;
        S_SHIFT: if (tick) begin
          if (!sclk_r) sclk_r <= 1'b1;
          else begin
            sclk_r <= 1'b0;
            if (last_slot) begin
              cs_r <= 1'b0;
              wcnt <= '0;
              st   <= needs_poll(op_r) ? S_GAP_MID : S_GAP_END;
            end else begin
              slot <= slot + 1'b1;
            end
          end
        end
        S_GAP_MID: begin
          if (gap_over) begin
            cs_r <= 1'b1;
            wcnt <= '0;
            st   <= S_POLL;
          end else wcnt <= wcnt + 1'b1;
        end
        S_POLL: begin
          if (poll_ready || poll_expire) begin
            cs_r  <= 1'b0;
            wcnt  <= '0;
            err_r <= poll_expire;
            st    <= S_GAP_END;
          end else wcnt <= wcnt + 1'b1;
        end
        S_GAP_END: begin
          if (gap_over) begin
            done_r <= 1'b1;
            if (op_r == OP_READ) rdata_r <= rx_q;
            st <= S_IDLE;
          end else wcnt <= wcnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ee_cs       = cs_r;
  assign ee_sclk     = sclk_r;
  assign ee_di       = cs_r & tx_q[FRAME_BITS-1];
  assign done        = done_r;
  assign rdata       = rdata_r;
  assign timeout_err = err_r;
endmodule

// File: rtl/ueh_host_chk.sv
module ueh_host_chk #(
  parameter int unsigned DIV    = 32,
  parameter int unsigned CS_GAP = 32
) (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic sclk,
  input logic di,
  input logic done,
  input logic err,
  input logic accept,
  input logic poll_expire
);
  logic [31:0] lowcnt, hicnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lowcnt <= 32'(CS_GAP);
      hicnt  <= '0;
    end else begin
      lowcnt <= cs ? 32'd0 : ((lowcnt == 32'hFFFF_FFFF) ? lowcnt : lowcnt + 32'd1);
      hicnt  <= sclk ? hicnt + 32'd1 : 32'd0;
    end
  end

  // R8
  sclk_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n) !cs |-> !sclk);
  // R3
  di_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) sclk && $past(sclk) |-> $stable(di));
  // R2
  sclk_high_len_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(sclk) |-> hicnt == 32'(DIV));
  // R7
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(cs) |-> lowcnt >= 32'(CS_GAP));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R6
  timeout_flag_chk: assert property (@(posedge clk) disable iff (!rst_n) poll_expire |=> err);
  // R9
  accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) accept |-> !cs);
endmodule

bind uwire_eeprom_host ueh_host_chk #(.DIV(DIV), .CS_GAP(CS_GAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(ee_cs), .sclk(ee_sclk), .di(ee_di),
  .done(done), .err(timeout_err), .accept(accept), .poll_expire(poll_expire)
);

// File: tb/tb_uwire_eeprom_host.sv
module tb_uwire_eeprom_host;
  localparam int DIV_T = 2, GAP_T = 5, PMAX_T = 200, BUSY_T = 30;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [5:0] cmd_addr = '0;
  logic [15:0] cmd_wdata = '0;
  logic done, timeout_err, ee_cs, ee_sclk, ee_di, ee_do;
  logic [15:0] rdata;

  int checks = 0, errors = 0, cyc = 0;

  always #4 clk = ~clk;

  uwire_eeprom_host #(.DIV(DIV_T), .CS_GAP(GAP_T), .POLL_MAX(PMAX_T)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .done(done), .rdata(rdata),
    .timeout_err(timeout_err), .ee_cs(ee_cs), .ee_sclk(ee_sclk),
    .ee_di(ee_di), .ee_do(ee_do)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // ---------------- memory model and link monitor ----------------
  logic [15:0] mem [64];
  bit m_wen = 0, m_st = 0, m_done = 0, m_rd = 0, m_rbit = 0, stuck = 0;
  int m_nb = 0, m_need = 0, m_ridx = 0, m_busy = 0;
  logic [24:0] m_sh;
  logic [1:0] m_op;
  logic [5:0] m_ad;
  // records
  int frames = 0, windows = 0, rises = 0, rec_rises = 0, last_high = 0;
  logic [1:0] rec_op;
  logic [5:0] rec_ad;
  logic [15:0] rec_data;
  // monitor state
  bit cs_p = 0, sclk_p = 0, di_p = 0;
  int lowc = GAP_T, hic = 0, lowph = 0, since_cs = 0, highc = 0;

  assign ee_do = m_rd ? m_rbit : (ee_cs ? ((m_busy != 0 || stuck) ? 1'b0 : 1'b1) : 1'b0);

  initial for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF;

  always @(negedge clk) begin
    cyc++;
    if (m_busy > 0) m_busy--;
    if (rst_n) begin
      if (ee_cs && !cs_p) begin
        chk(lowc >= GAP_T, "R7 cs low gap", lowc, GAP_T);
        windows++; rises = 0; since_cs = 0; highc = 0;
      end
      if (ee_cs) begin since_cs++; highc++; end
      if (!ee_cs && cs_p) last_high = highc;
      if (ee_sclk && !ee_cs) chk(0, "R8 sclk while cs low", 1, 0);
      if (ee_sclk && !sclk_p) begin
        if (rises == 0) chk(since_cs > DIV_T, "R2 cs setup", since_cs, DIV_T);
        else chk(lowph == DIV_T, "R2 low phase", lowph, DIV_T);
        rises++; hic = 1;
        // model: process a rising edge
        if (m_rd) begin
          if (m_ridx < 16) m_rbit = mem[m_ad][15 - m_ridx];
          m_ridx++;
        end else if (!m_st) begin
          if (ee_di) begin m_st = 1; m_nb = 0; m_sh = '0; m_need = 8; end
        end else if (!m_done) begin
          m_sh = {m_sh[23:0], ee_di}; m_nb++;
          if (m_nb == 8) begin
            m_op = m_sh[7:6]; m_ad = m_sh[5:0];
            if (m_op == 2'b10) begin m_rd = 1; m_rbit = 0; m_ridx = 0; m_done = 1; end
            else if (m_op == 2'b01 || (m_op == 2'b00 && m_ad[5:4] == 2'b01)) m_need = 24;
            else m_done = 1;
          end else if (m_nb == m_need) m_done = 1;
        end
      end else if (ee_sclk && sclk_p) begin
        hic++;
        chk(ee_di == di_p, "R3 di stable while sclk high", ee_di, di_p);
      end
      if (!ee_sclk && sclk_p) begin
        chk(hic == DIV_T, "R2 high phase", hic, DIV_T);
        lowph = 1;
      end else if (!ee_sclk && ee_cs) lowph++;
      if (!ee_cs && cs_p) begin
        if (m_done) begin
          frames++; rec_op = m_op; rec_ad = m_ad; rec_data = m_sh[15:0]; rec_rises = rises;
          if (m_op == 2'b00 && m_ad[5:4] == 2'b11) m_wen = 1;
          else if (m_op == 2'b00 && m_ad[5:4] == 2'b00) m_wen = 0;
          else if (m_op != 2'b10 && m_wen) begin
            m_busy = BUSY_T;
            if (m_op == 2'b01) mem[m_ad] = m_sh[15:0];
            else if (m_op == 2'b11) mem[m_ad] = 16'hFFFF;
            else if (m_ad[5:4] == 2'b10) for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF;
            else for (int i = 0; i < 64; i++) mem[i] = m_sh[15:0];
          end
        end
        m_st = 0; m_done = 0; m_rd = 0;
      end
      lowc = ee_cs ? 0 : lowc + 1;
    end
    cs_p = ee_cs; sclk_p = ee_sclk; di_p = ee_di;
  end

  // ---------------- bench-side expectations ----------------
  logic [15:0] shadow [64];
  bit sh_wen = 0;
  initial for (int i = 0; i < 64; i++) shadow[i] = 16'hFFFF;

  function automatic logic [7:0] exp_hdr(int op, logic [5:0] a);
    case (op)
      0: return {2'b10, a};
      1: return {2'b01, a};
      2: return {2'b11, a};
      3: return {2'b00, 6'h20};
      4: return {2'b00, 6'h10};
      5: return {2'b00, 6'h30};
      default: return {2'b00, 6'h00};
    endcase
  endfunction

  function automatic logic [15:0] pat(int a);
    return 16'((a * 16'h0413) ^ 16'hA5C3);
  endfunction

  task automatic do_cmd(input int op, input int a, input logic [15:0] wd, input bit exp_err);
    int f0, w0, n;
    bit prog, dat;
    prog = (op >= 1 && op <= 4);
    dat  = (op == 1 || op == 4);
    f0 = frames; w0 = windows;
    @(negedge clk);
    cmd_valid = 1; cmd_op = 3'(op); cmd_addr = 6'(a); cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 0;
    n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    if (n >= 5000) begin chk(0, "R8 done never came", 0, 1); return; end
    chk(lowc >= GAP_T, "R7 cs low before done", lowc, GAP_T);
    chk(frames == f0 + 1, "R1 one frame sent", frames - f0, 1);
    chk({rec_op, rec_ad} == exp_hdr(op, 6'(a)), "R1 header bits", {rec_op, rec_ad}, exp_hdr(op, 6'(a)));
    if (dat) chk(rec_data == wd, "R1 data bits", rec_data, wd);
    chk(rec_rises == (op == 0 ? 26 : (dat ? 25 : 9)), "R2 rising edge count", rec_rises, (op == 0 ? 26 : (dat ? 25 : 9)));
    if (prog) chk(windows - w0 == 2, "R5 poll window present", windows - w0, 2);
    else      chk(windows - w0 == 1, "R10 no poll window", windows - w0, 1);
    chk(timeout_err == exp_err, "R6 timeout flag", timeout_err, exp_err);
    if (op == 0) chk(rdata == shadow[a], "R4 read data", rdata, shadow[a]);
    // bench-side memory expectations
    if (op == 5) sh_wen = 1;
    else if (op == 6 || op == 7) sh_wen = 0;
    else if (prog && sh_wen) begin
      if (op == 1) shadow[a] = wd;
      else if (op == 2) shadow[a] = 16'hFFFF;
      else for (int i = 0; i < 64; i++) shadow[i] = (op == 3) ? 16'hFFFF : wd;
    end
    @(negedge clk);
    chk(done == 0, "R8 done single cycle", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ee_cs == 0 && ee_sclk == 0 && done == 0, "R8 reset outputs", {ee_cs, ee_sclk, done}, 0);
    chk(timeout_err == 0 && rdata == 0, "R6 reset flag and data", {timeout_err, rdata}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    do_cmd(1, 3, 16'h1234, 0);        // write while protected
    do_cmd(0, 3, 16'h0, 0);           // R4: still erased
    do_cmd(5, 0, 16'h0, 0);           // enable
    for (int a = 0; a < 64; a++) do_cmd(1, a, pat(a), 0);
    for (int a = 0; a < 64; a++) do_cmd(0, a, 16'h0, 0);
    do_cmd(2, 5, 16'h0, 0);
    do_cmd(0, 5, 16'h0, 0);
    do_cmd(0, 6, 16'h0, 0);
    do_cmd(4, 0, 16'h5A0F, 0);
    for (int a = 0; a < 64; a++) do_cmd(0, a, 16'h0, 0);
    do_cmd(3, 0, 16'h0, 0);
    do_cmd(0, 0, 16'h0, 0);
    do_cmd(0, 63, 16'h0, 0);
    do_cmd(6, 0, 16'h0, 0);
    do_cmd(7, 0, 16'h0, 0);           // unused code sends disable
    do_cmd(1, 1, 16'hBEEF, 0);
    do_cmd(0, 1, 16'h0, 0);
    do_cmd(5, 0, 16'h0, 0);

    // R9: strobe during a busy command is ignored
    begin
      int f0, w0, n, dn;
      f0 = frames; w0 = windows;
      @(negedge clk);
      cmd_valid = 1; cmd_op = 3'd1; cmd_addr = 6'd7; cmd_wdata = 16'hC0DE;
      @(negedge clk); cmd_valid = 0;
      repeat (20) @(negedge clk);
      cmd_valid = 1; cmd_op = 3'd0; cmd_addr = 6'd9;
      repeat (3) @(negedge clk);
      cmd_valid = 0;
      n = 0; while (!done && n < 5000) begin @(negedge clk); n++; end
      shadow[7] = 16'hC0DE;
      dn = 0;
      repeat (60) begin @(negedge clk); if (done) dn++; end
      chk(frames == f0 + 1, "R9 extra strobe started no frame", frames - f0, 1);
      chk(windows == w0 + 2, "R9 no extra select window", windows - w0, 2);
      chk(dn == 0, "R9 no extra done", dn, 0);
      do_cmd(0, 7, 16'h0, 0);
    end

    // R6: memory never ready
    stuck = 1;
    do_cmd(2, 8, 16'h0, 1);
    chk(last_high == PMAX_T, "R6 poll length", last_high, PMAX_T);
    stuck = 0;
    do_cmd(0, 8, 16'h0, 0);           // flag cleared on next accept
    do_cmd(1, 8, 16'h0F0F, 0);
    do_cmd(0, 8, 16'h0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 190000);
    errors++; checks++;
    $display("FAIL watchdog expired after %0d cycles (expected completion)", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule